// File: doc/BRIEF.md
# Trace Control Register Access Gate

This block sits beside the system-register decode path of a processor core and handles every access aimed at one 64-bit trace-unit control register. It first decides whether the access encoding names this register. If it does, it walks a fixed ladder of trap checks chosen by the current exception level. The result says whether the access is allowed, undefined, or sent as a trap to exception level 1, 2 or 3. The outcome, the trap target, the syndrome class and any read data all appear combinationally in the same cycle as the request.

The block also holds the register. The low nibble reports a build-time capability code and is read-only. The next nibble is a feature-control field that software may write. Every bit above these two nibbles reads as zero. When the capability code is zero, the control field is reserved: it reads as zero and ignores writes.

The block has one stored state, the control field, with two transitions. In HOLD the field keeps its value; this happens on every cycle without a permitted write. In LOAD the field takes write-data bits [7:4] at the clock edge; this happens on a permitted, valid write. Reset places the field at zero. The decision steps are named per level in R3, R5 and R6.

Top module: `trace_access_ctl`

## Requirements
- R1: The register matches only when op0=2'b10, op1=3'b001, CRn=4'b0000, CRm=4'b0000 and op2=3'b111. Any other encoding gives result code 3 (no-match), with trap level 0, class 0 and read data 0. A write with any other encoding leaves the control field unchanged.
- R2: A matching access at level 0 gives result code 1 (undefined).
- R3: At level 1 the first check that holds decides the result, in this order: the debug override (R4); the level-1 trace trap, which traps to level 1; level 2 enabled with the level-2 trace trap, which traps to level 2; the fine-grained rule (R7), which traps to level 2; level 3 present with the level-3 trace trap, which gives undefined when halted with secure debug disabled and otherwise traps to level 3. If none holds, the result is code 0 (allow).
- R4: When the priority parameter is set, an access at level 1 or 2 is undefined if all of these hold: halted, level 3 present, secure debug disabled, and the level-3 trace trap set. This check overrides every other check at those levels.
- R5: At level 2 the checks are the debug override, then the level-2 trace trap (trap to level 2, whether or not level 2 is enabled), then the level-3 rule of R3, then allow. The level-1 trace trap and the fine-grained bits have no effect at level 2.
- R6: At level 3 the level-3 trace trap traps to level 3, even when halted with secure debug disabled. Otherwise the access is allowed.
- R7: The fine-grained rule applies only at level 1, and only when level 2 is enabled and either level 3 is absent or the fine-grained enable is set. Reads use the read trap bit and writes use the write trap bit.
- R8: A trap gives result code 2, class 6'h18, and trap level 1, 2 or 3. Every other result gives trap level 0 and class 0.
- R9: A permitted read returns the capability code in bits [3:0], the control field in bits [7:4] and zero above, in the same cycle. Every other access returns zero read data.
- R10: The control field resets to 0. A valid, permitted write loads write-data bits [7:4] at the next clock edge.
- R11: A write that is undefined or trapped leaves the control field unchanged.
- R12: With a capability code of 0, the control field reads as zero and ignores permitted writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low trace-unit reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_wdata | input | 64 | Write data |
| cur_el | input | 2 | Current exception level |
| halted | input | 1 | Core is in halted debug state |
| el2_enabled | input | 1 | Level 2 is implemented and enabled |
| el3_present | input | 1 | Level 3 is implemented |
| el1_trc_trap | input | 1 | Level-1 trace-access trap control |
| el2_trc_trap | input | 1 | Level-2 trace-access trap control |
| el3_trc_trap | input | 1 | Level-3 trace-access trap control |
| fgt_enable | input | 1 | Level-3 permission for fine-grained traps |
| sec_dbg_off | input | 1 | Secure debug disabled |
| fgt_rd_trap | input | 1 | Fine-grained read trap bit |
| fgt_wr_trap | input | 1 | Fine-grained write trap bit |
| result | output | 2 | 0 allow, 1 undefined, 2 trap, 3 no-match |
| trap_el | output | 2 | Target level of a trap, 0 otherwise |
| syndrome_ec | output | 6 | Exception class of a trap, 0 otherwise |
| rdata | output | 64 | Read data for a permitted read |

## Verification
The only stored state is the control nibble. If it is corrupted, or loaded by an access that should have been refused, the error stays hidden until the next permitted read. That read shows it in bits [7:4] in the same cycle, so each write scenario is followed at once by a read-back. A wrong decision in the check ladder shows up in the same cycle as the request, as a wrong result, trap level or class. For that reason each priority pair is driven with both conditions set, so that a swapped order changes the output.

// File: rtl/trace_acc_pkg.sv
`timescale 1ns/1ps
package trace_acc_pkg;

    typedef enum logic [1:0] {
        RES_ALLOW   = 2'd0,
        RES_UNDEF   = 2'd1,
        RES_TRAP    = 2'd2,
        RES_NOMATCH = 2'd3
    } acc_res_e;

    typedef enum logic [1:0] {
        LVL0 = 2'd0,
        LVL1 = 2'd1,
        LVL2 = 2'd2,
        LVL3 = 2'd3
    } exc_lvl_e;

    localparam int        ENC_W      = 16;
    localparam int        CLASS_W    = 6;
    localparam logic [CLASS_W-1:0] TRAP_CLASS = 6'h18;

endpackage

// File: rtl/enc_match.sv
`timescale 1ns/1ps
module enc_match #(
    parameter int                 W         = 16,
    parameter logic [W-1:0]       MATCH_ENC = 16'b10_001_0000_0000_111
) (
    input  logic [W-1:0] enc,
    output logic         hit
);
    always_comb begin
        hit = (enc == MATCH_ENC);
    end
endmodule

// File: rtl/trap_arbiter.sv
`timescale 1ns/1ps
module trap_arbiter
    import trace_acc_pkg::*;
#(
    parameter bit EL3_PRIO = 1'b1
) (
    input  logic     hit,
    input  exc_lvl_e lvl,
    input  logic     is_write,
    input  logic     halted,
    input  logic     el2_en,
    input  logic     el3_here,
    input  logic     t1,
    input  logic     t2,
    input  logic     t3,
    input  logic     fgt_en,
    input  logic     sdis,
    input  logic     frd,
    input  logic     fwr,
    output acc_res_e res,
    output logic [1:0] tgt
);
    logic ovr;
    logic fgt_hit;
    logic dbg_block;

    always_comb begin
        dbg_block = halted && sdis;
        ovr       = EL3_PRIO && dbg_block && el3_here && t3;
        fgt_hit   = el2_en && (!el3_here || fgt_en) && (is_write ? fwr : frd);
    end

    always_comb begin
        res = RES_ALLOW;
        tgt = 2'd0;
        unique case (lvl)
            LVL0: res = RES_UNDEF;
            LVL1: begin
                if (ovr) begin
                    res = RES_UNDEF;
                end else if (t1) begin
                    res = RES_TRAP; tgt = 2'd1;
                end else if (el2_en && t2) begin
                    res = RES_TRAP; tgt = 2'd2;
                end else if (fgt_hit) begin
                    res = RES_TRAP; tgt = 2'd2;
                end else if (el3_here && t3) begin
                    if (dbg_block) res = RES_UNDEF;
                    else begin res = RES_TRAP; tgt = 2'd3; end
                end
            end
            LVL2: begin
                if (ovr) begin
                    res = RES_UNDEF;
                end else if (t2) begin
                    res = RES_TRAP; tgt = 2'd2;
                end else if (el3_here && t3) begin
                    if (dbg_block) res = RES_UNDEF;
                    else begin res = RES_TRAP; tgt = 2'd3; end
                end
            end
            LVL3: begin
                if (t3) begin
                    res = RES_TRAP; tgt = 2'd3;
                end
            end
        endcase
        if (!hit) begin
            res = RES_NOMATCH;
            tgt = 2'd0;
        end
    end
endmodule

// File: rtl/feat_reg.sv
`timescale 1ns/1ps
module feat_reg #(
    parameter int            FW   = 4,
    parameter logic [FW-1:0] CAPS = 4'h3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  logic [FW-1:0] wfield,
    output logic [FW-1:0] ctl
);
    logic          load;
    logic [FW-1:0] ctl_q;

    generate
        if (CAPS != '0) begin : g_live
            assign load = commit;
        end else begin : g_rsvd
            assign load = 1'b0;
            AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                ctl == '0);  // R12
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ctl_q <= '0;
        else if (load) ctl_q <= wfield;
    end

    assign ctl = ctl_q;

    AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(ctl));  // R11
endmodule

// File: rtl/trace_access_ctl.sv
`timescale 1ns/1ps
module trace_access_ctl
    import trace_acc_pkg::*;
#(
    parameter int         REG_W    = 64,
    parameter int         FW       = 4,
    parameter logic [3:0] IMPL_CAPS = 4'h3,
    parameter bit         EL3_PRIO = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [1:0]  req_op0,
    input  logic [2:0]  req_op1,
    input  logic [3:0]  req_crn,
    input  logic [3:0]  req_crm,
    input  logic [2:0]  req_op2,
    input  logic        req_write,
    input  logic [63:0] req_wdata,
    input  logic [1:0]  cur_el,
    input  logic        halted,
    input  logic        el2_enabled,
    input  logic        el3_present,
    input  logic        el1_trc_trap,
    input  logic        el2_trc_trap,
    input  logic        el3_trc_trap,
    input  logic        fgt_enable,
    input  logic        sec_dbg_off,
    input  logic        fgt_rd_trap,
    input  logic        fgt_wr_trap,
    output logic [1:0]  result,
    output logic [1:0]  trap_el,
    output logic [5:0]  syndrome_ec,
    output logic [63:0] rdata
);
    localparam int LOW_W = 2 * FW;
    localparam int UP_W  = REG_W - LOW_W;
    localparam logic [ENC_W-1:0] TARGET = 16'b10_001_0000_0000_111;

    logic [ENC_W-1:0] enc;
    logic             hit;
    acc_res_e         arb_res;
    logic [1:0]       arb_tgt;
    logic             commit;
    logic [FW-1:0]    ctl;
    logic [REG_W-1:0] image;

    assign enc = {req_op0, req_op1, req_crn, req_crm, req_op2};

    enc_match #(.W(ENC_W), .MATCH_ENC(TARGET)) u_match (
        .enc (enc),
        .hit (hit)
    );

    trap_arbiter #(.EL3_PRIO(EL3_PRIO)) u_arb (
        .hit      (hit),
        .lvl      (exc_lvl_e'(cur_el)),
        .is_write (req_write),
        .halted   (halted),
        .el2_en   (el2_enabled),
        .el3_here (el3_present),
        .t1       (el1_trc_trap),
        .t2       (el2_trc_trap),
        .t3       (el3_trc_trap),
        .fgt_en   (fgt_enable),
        .sdis     (sec_dbg_off),
        .frd      (fgt_rd_trap),
        .fwr      (fgt_wr_trap),
        .res      (arb_res),
        .tgt      (arb_tgt)
    );

    assign commit = req_valid && req_write && (arb_res == RES_ALLOW);

    feat_reg #(.FW(FW), .CAPS(IMPL_CAPS[FW-1:0])) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .wfield (req_wdata[LOW_W-1:FW]),
        .ctl    (ctl)
    );

    assign image = {{UP_W{1'b0}}, ctl, IMPL_CAPS[FW-1:0]};

    always_comb begin
        result      = arb_res;
        trap_el     = 2'd0;
        syndrome_ec = '0;
        rdata       = '0;
        if (arb_res == RES_TRAP) begin
            trap_el     = arb_tgt;
            syndrome_ec = TRAP_CLASS;
        end
        if (arb_res == RES_ALLOW && !req_write) begin
            rdata = image;
        end
    end

    AST_NOMATCH_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (enc != TARGET) |-> (result == 2'd3 && rdata == '0));  // R1
    AST_EL0_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
        (enc == TARGET && cur_el == 2'd0) |-> (result == 2'd1));  // R2
    AST_DBG_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (EL3_PRIO && enc == TARGET && (cur_el == 2'd1 || cur_el == 2'd2) && halted
         && el3_present && sec_dbg_off && el3_trc_trap) |-> (result == 2'd1));  // R4
    AST_EL3_NO_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
        (enc == TARGET && cur_el == 2'd3) |-> (result != 2'd1));  // R6
    AST_TRAP_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (result == 2'd2) |-> (syndrome_ec == 6'h18 && trap_el != 2'd0));  // R8
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[REG_W-1:LOW_W] == '0);  // R9
    AST_BLOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && result != 2'd0) |=> $stable(ctl));  // R11
endmodule

// File: tb/sim_trace_access_ctl.sv
`timescale 1ns/1ps
module sim_trace_access_ctl;

    typedef struct packed {
        logic [1:0]  op0;
        logic [2:0]  op1;
        logic [3:0]  crn;
        logic [3:0]  crm;
        logic [2:0]  op2;
        logic        wr;
        logic [63:0] wdata;
        logic [1:0]  el;
        logic        halted;
        logic        el2_en;
        logic        el3_p;
        logic        t1;
        logic        t2;
        logic        t3;
        logic        fgt_en;
        logic        sdis;
        logic        frd;
        logic        fwr;
    } stim_t;

    typedef struct packed {
        logic [1:0]  res;
        logic [1:0]  tel;
        logic [5:0]  ec;
        logic [63:0] rd0;
        logic [63:0] rd1;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        req_valid = 1'b0;
    stim_t       cur = '0;
    logic [1:0]  res0, tel0, res1, tel1;
    logic [5:0]  ec0, ec1;
    logic [63:0] rd0, rd1;

    trace_access_ctl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_op0(cur.op0), .req_op1(cur.op1), .req_crn(cur.crn), .req_crm(cur.crm),
        .req_op2(cur.op2), .req_write(cur.wr), .req_wdata(cur.wdata), .cur_el(cur.el),
        .halted(cur.halted), .el2_enabled(cur.el2_en), .el3_present(cur.el3_p),
        .el1_trc_trap(cur.t1), .el2_trc_trap(cur.t2), .el3_trc_trap(cur.t3),
        .fgt_enable(cur.fgt_en), .sec_dbg_off(cur.sdis),
        .fgt_rd_trap(cur.frd), .fgt_wr_trap(cur.fwr),
        .result(res0), .trap_el(tel0), .syndrome_ec(ec0), .rdata(rd0)
    );

    trace_access_ctl #(.IMPL_CAPS(4'h0)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_op0(cur.op0), .req_op1(cur.op1), .req_crn(cur.crn), .req_crm(cur.crm),
        .req_op2(cur.op2), .req_write(cur.wr), .req_wdata(cur.wdata), .cur_el(cur.el),
        .halted(cur.halted), .el2_enabled(cur.el2_en), .el3_present(cur.el3_p),
        .el1_trc_trap(cur.t1), .el2_trc_trap(cur.t2), .el3_trc_trap(cur.t3),
        .fgt_enable(cur.fgt_en), .sec_dbg_off(cur.sdis),
        .fgt_rd_trap(cur.frd), .fgt_wr_trap(cur.fwr),
        .result(res1), .trap_el(tel1), .syndrome_ec(ec1), .rdata(rd1)
    );

    exp_t  exp_q[$];
    string tag_q[$];
    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    logic [3:0] ctl_m = 4'h0;

    function automatic stim_t base();
        stim_t s = '0;
        s.op0 = 2'b10; s.op1 = 3'b001; s.op2 = 3'b111; s.el = 2'd1;
        return s;
    endfunction

    // Expected outcome written from the requirement text.
    function automatic logic [3:0] predict(stim_t s);
        logic ovr;
        if ({s.op0, s.op1, s.crn, s.crm, s.op2} != 16'b10_001_0000_0000_111) return {2'd3, 2'd0};
        if (s.el == 2'd0) return {2'd1, 2'd0};
        if (s.el == 2'd3) return s.t3 ? {2'd2, 2'd3} : {2'd0, 2'd0};
        ovr = s.halted && s.el3_p && s.sdis && s.t3;
        if (ovr) return {2'd1, 2'd0};
        if (s.el == 2'd1 && s.t1) return {2'd2, 2'd1};
        if (s.el == 2'd1 && s.el2_en && s.t2) return {2'd2, 2'd2};
        if (s.el == 2'd2 && s.t2) return {2'd2, 2'd2};
        if (s.el == 2'd1 && s.el2_en && (!s.el3_p || s.fgt_en) && (s.wr ? s.fwr : s.frd))
            return {2'd2, 2'd2};
        if (s.el3_p && s.t3) return (s.halted && s.sdis) ? {2'd1, 2'd0} : {2'd2, 2'd3};
        return {2'd0, 2'd0};
    endfunction

    task automatic go(input stim_t s, input string tag);
        logic [3:0] p;
        exp_t e;
        @(posedge clk);
        #1;
        cur = s;
        req_valid = 1'b1;
        p = predict(s);
        e.res = p[3:2];
        e.tel = p[1:0];
        e.ec  = (p[3:2] == 2'd2) ? 6'h18 : 6'h00;
        e.rd0 = (p[3:2] == 2'd0 && !s.wr) ? {56'd0, ctl_m, 4'h3} : 64'd0;
        e.rd1 = 64'd0;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        if (p[3:2] == 2'd0 && s.wr) ctl_m = s.wdata[7:4];
    endtask

    task automatic idle();
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        cur = base();
    endtask

    // Monitor: pop and compare away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                total++;
                if (res0 !== e.res || tel0 !== e.tel || ec0 !== e.ec || rd0 !== e.rd0 ||
                    res1 !== e.res || tel1 !== e.tel || ec1 !== e.ec || rd1 !== e.rd1) begin
                    bad++;
                    $display("FAIL %s res=%0d/%0d tel=%0d/%0d ec=%h/%h rd0=%h/%h | caps0: res=%0d tel=%0d ec=%h rd=%h (expected res=%0d rd=%h)",
                             t, res0, e.res, tel0, e.tel, ec0, e.ec, rd0, e.rd0,
                             res1, tel1, ec1, rd1, e.res, e.rd1);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog all requirements actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        stim_t s;
        cur = base();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10 reset value of the control field, R9 read layout
        s = base(); go(s, "R10 reset read");
        // R1 other encodings
        s = base(); s.op2 = 3'b110; go(s, "R1 op2 differs");
        s = base(); s.crm = 4'b0001; go(s, "R1 crm differs");
        // R2 level 0
        s = base(); s.el = 2'd0; go(s, "R2 el0");
        // R3 level 1 ordering
        s = base(); s.t1 = 1; go(s, "R3 el1 trap");
        s = base(); s.t1 = 1; s.el2_en = 1; s.t2 = 1; go(s, "R3 el1 beats el2");
        s = base(); s.t2 = 1; go(s, "R3 el2 trap needs enable");
        s = base(); s.el2_en = 1; s.t2 = 1; s.el3_p = 1; s.t3 = 1; go(s, "R3 el2 beats el3");
        s = base(); s.el3_p = 1; s.t3 = 1; go(s, "R3 el3 trap");
        s = base(); s.el3_p = 1; s.t3 = 1; s.t1 = 1; go(s, "R3 el1 beats el3 not halted");
        s = base(); s.el3_p = 1; s.t3 = 1; s.halted = 1; go(s, "R3 halted only");
        s = base(); s.el3_p = 0; s.t3 = 1; go(s, "R3 el3 absent");
        // R7 fine-grained
        s = base(); s.el2_en = 1; s.frd = 1; go(s, "R7 read bit");
        s = base(); s.el2_en = 1; s.frd = 1; s.wr = 1; s.wdata = 64'h00; go(s, "R7 read bit on write");
        s = base(); s.el2_en = 1; s.fwr = 1; s.wr = 1; s.wdata = 64'h10; go(s, "R7 write bit");
        s = base(); s.el2_en = 1; s.frd = 1; s.el3_p = 1; go(s, "R7 blocked by fgt enable");
        s = base(); s.el2_en = 1; s.frd = 1; s.el3_p = 1; s.fgt_en = 1; go(s, "R7 fgt enabled");
        s = base(); s.frd = 1; go(s, "R7 el2 disabled");
        // R4 override
        s = base(); s.el3_p = 1; s.t3 = 1; s.halted = 1; s.sdis = 1; s.t1 = 1; go(s, "R4 el1 override");
        s = base(); s.el = 2'd2; s.el3_p = 1; s.t3 = 1; s.halted = 1; s.sdis = 1; s.t2 = 1; go(s, "R4 el2 override");
        // R5 level 2
        s = base(); s.el = 2'd2; s.t1 = 1; s.el2_en = 1; s.frd = 1; go(s, "R5 el1 and fgt ignored");
        s = base(); s.el = 2'd2; s.t2 = 1; go(s, "R5 el2 trap");
        s = base(); s.el = 2'd2; s.el3_p = 1; s.t3 = 1; go(s, "R5 el3 trap");
        // R6 level 3
        s = base(); s.el = 2'd3; s.el3_p = 1; s.t3 = 1; s.halted = 1; s.sdis = 1; go(s, "R6 el3 no override");
        s = base(); s.el = 2'd3; s.el3_p = 1; s.t1 = 1; s.t2 = 1; s.el2_en = 1; s.frd = 1; go(s, "R6 el3 allow");
        // R10 R12 permitted write then read back
        s = base(); s.wr = 1; s.wdata = 64'hFFFF_FFFF_FFFF_FF5A; go(s, "R10 permitted write");
        s = base(); go(s, "R12 read back after write");
        // R11 trapped, undefined writes; R1 non-matching write
        s = base(); s.wr = 1; s.t1 = 1; s.wdata = 64'hA0; go(s, "R11 trapped write");
        s = base(); go(s, "R11 read after trapped write");
        s = base(); s.wr = 1; s.el = 2'd0; s.wdata = 64'hB0; go(s, "R11 undefined write");
        s = base(); go(s, "R11 read after undefined write");
        s = base(); s.wr = 1; s.op1 = 3'b000; s.wdata = 64'hC0; go(s, "R1 nonmatching write");
        s = base(); go(s, "R1 read after nonmatching write");
        s = base(); s.t2 = 1; s.el2_en = 1; go(s, "R9 trapped read zero data");
        s = base(); s.el = 2'd2; s.wr = 1; s.wdata = 64'h0000_0000_0000_00F0; go(s, "R10 el2 write");
        s = base(); s.el = 2'd3; go(s, "R9 el3 read back");

        idle();
        repeat (4) @(posedge clk);
        if (exp_q.size() != 0) begin
            total++;
            bad++;
            $display("FAIL scoreboard all requirements actual=%0d pending expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule